// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a small 16-bit processor core from normal execution into an exception handler. Every cycle it is idle it looks at the non-maskable request, the eight external request lines, a set of internal peripheral requests and a trap request that carries a 2-bit entry number. It picks one winner and latches the current program counter, condition code byte, stack pointer and interrupt control mode. It then runs a fixed sequence. First it pushes the program counter and the condition code byte onto the stack through a word write port with a ready handshake. Next it reads the 32-bit handler address from the vector table. Last it loads the new program counter and the updated condition code byte back into the core.

The stack grows downward and is byte addressed with 16-bit words. Each push decrements the stack pointer by one word before writing. Vector numbers are fixed per source, and a vector's table address is its number times four. The core holds off instruction execution while `busy` is high.

Top module: `exc_entry_seq`

## Requirements
- R1: The non-maskable request wins over every other source, including a pending trap, and is taken even when CCR bit 7 (I) is 1. It uses vector number 7.
- R2: A trap is taken whatever the value of CCR bit 7. It beats every IRQ and peripheral request. Its vector number is 8 plus `trap_num` (8 to 11).
- R3: Among maskable sources, IRQ lines beat peripheral lines. Within each group the lowest index wins. IRQn uses vector 16+n and peripheral k uses vector 64+k.
- R4: When CCR bit 7 is 1 and only IRQ or peripheral requests are present, no entry starts: `busy`, `wr_en` and `rd_en` all stay low.
- R5: The first write stores the saved PC at SP−2. The second stores the saved CCR, zero-extended to 16 bits, at SP−4. Each write is held until `wr_ready` is sampled high, and exactly two handshakes occur per entry.
- R6: After both pushes, one read is issued at address vector×4. `pc_out` takes the low 16 bits of the returned word and is presented with a one-cycle `pc_load` pulse. At the same time `sp_out` equals the latched SP minus 4.
- R7: On trap entry the new CCR has bit 7 (I) set in both control modes. Bit 6 (UI) keeps its old value in mode 0 (`icm`=0) and is set in mode 1. All other bits are unchanged.
- R8: On interrupt entry (non-maskable, IRQ or peripheral), the CCR is updated the same way: I is set, UI is set only in mode 1, and the other bits are unchanged.
- R9: `busy` rises the cycle after acceptance and falls the cycle after `pc_load`. Request changes while `busy` is high have no effect on the entry in progress and start nothing once they are withdrawn.
- R10: While reset is asserted, `busy`, `wr_en`, `rd_en`, `pc_load` and `ccr_load` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request (level) |
| irq_req | input | 8 | External request lines, index 0 highest |
| per_req | input | 4 | Internal peripheral requests, index 0 highest |
| trap_req | input | 1 | Trap request from the decoder |
| trap_num | input | 2 | Trap entry number 0..3 |
| icm | input | 1 | Interrupt control mode (0 or 1) |
| pc_in | input | 16 | Current program counter |
| ccr_in | input | 8 | Current CCR (bit 7 I, bit 6 UI) |
| sp_in | input | 16 | Current stack pointer |
| wr_en | output | 1 | Stack write request |
| wr_addr | output | 16 | Stack write byte address |
| wr_data | output | 16 | Stack write data |
| wr_ready | input | 1 | Write accepted this cycle |
| rd_en | output | 1 | Vector table read request |
| rd_addr | output | 16 | Vector table byte address |
| rd_data | input | 32 | Vector table entry |
| rd_valid | input | 1 | Read data valid |
| busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | Load `pc_out` into PC (one cycle) |
| pc_out | output | 16 | Handler start address |
| ccr_load | output | 1 | Load `ccr_out` into CCR (one cycle) |
| ccr_out | output | 8 | Updated CCR |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
The bench builds the block with its default parameters: 8 IRQ lines, 4 peripheral lines, 16-bit PC and addresses, and peripheral vectors from 64. This brings every priority tier within reach, including the highest IRQ index and a peripheral index above zero. It also lets the bench check the vector address arithmetic against trap, NMI, IRQ and peripheral numbers that sit in separate parts of the table. A back-pressured write port and a one-cycle-late read response exercise the handshake waits in both directions.

// File: rtl/exc_pkg.sv
// Shared types and CCR bit positions for the exception entry sequencer.
// Assumes an 8-bit CCR with the interrupt mask in bit 7 and the user bit in bit 6.
package exc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CCR,
        ST_FETCH,
        ST_LOAD
    } exc_state_t;

    localparam int CCR_W      = 8;
    localparam int CCR_I_BIT  = 7;
    localparam int CCR_UI_BIT = 6;
endpackage

// File: rtl/exc_arbiter.sv
// Fixed-priority source selection.
// Order: non-maskable > trap > IRQ (low index first) > peripheral (low index first).
// Assumes `mask` holds off only IRQ and peripheral requests.
module exc_arbiter #(
    parameter int NUM_IRQ       = 8,
    parameter int NUM_PER       = 4,
    parameter int VEC_W         = 8,
    parameter int NMI_VEC       = 7,
    parameter int TRAP_VEC_BASE = 8,
    parameter int IRQ_VEC_BASE  = 16,
    parameter int PER_VEC_BASE  = 64
) (
    input  logic               nmi,
    input  logic               trap,
    input  logic [1:0]         trap_num,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_PER-1:0] per,
    input  logic               mask,
    output logic               win_valid,
    output logic [VEC_W-1:0]   win_vec,
    output logic               win_trap
);
    // Purpose: lower tiers are written first so that higher tiers override them.
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_trap  = 1'b0;
        for (int k = NUM_PER - 1; k >= 0; k--) begin
            if (per[k] && !mask) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(PER_VEC_BASE + k);
            end
        end
        for (int n = NUM_IRQ - 1; n >= 0; n--) begin
            if (irq[n] && !mask) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(IRQ_VEC_BASE + n);
            end
        end
        if (trap) begin
            win_valid = 1'b1;
            win_vec   = VEC_W'(TRAP_VEC_BASE) + VEC_W'(trap_num);
            win_trap  = 1'b1;
        end
        if (nmi) begin
            win_valid = 1'b1;
            win_vec   = VEC_W'(NMI_VEC);
            win_trap  = 1'b0;
        end
    end
endmodule

// File: rtl/exc_ccr_update.sv
// Computes the CCR value loaded on exception entry.
// I is always set; UI is set in control mode 1 and kept in mode 0.
// Assumes `icm` is a single bit selecting mode 0 or 1.
module exc_ccr_update
    import exc_pkg::*;
(
    input  logic [CCR_W-1:0] ccr_old,
    input  logic             icm,
    output logic [CCR_W-1:0] ccr_new
);
    // Purpose: force the mask bits and pass every other bit through.
    always_comb begin
        ccr_new = ccr_old;
        ccr_new[CCR_I_BIT] = 1'b1;
        if (icm) begin
            ccr_new[CCR_UI_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer.
// Accepts one source while idle, pushes PC then CCR, fetches the 32-bit vector,
// and loads PC/CCR. Assumes a byte-addressed, downward-growing stack of
// DATA_W-bit words and PC_W == DATA_W.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int NUM_IRQ       = 8,
    parameter int NUM_PER       = 4,
    parameter int PC_W          = 16,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int ENTRY_W       = 32,
    parameter int VEC_W         = 8,
    parameter int NMI_VEC       = 7,
    parameter int TRAP_VEC_BASE = 8,
    parameter int IRQ_VEC_BASE  = 16,
    parameter int PER_VEC_BASE  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_PER-1:0] per_req,
    input  logic               trap_req,
    input  logic [1:0]         trap_num,
    input  logic               icm,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [CCR_W-1:0]   ccr_in,
    input  logic [ADDR_W-1:0]  sp_in,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    input  logic               wr_ready,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [ENTRY_W-1:0] rd_data,
    input  logic               rd_valid,
    output logic               busy,
    output logic               pc_load,
    output logic [PC_W-1:0]    pc_out,
    output logic               ccr_load,
    output logic [CCR_W-1:0]   ccr_out,
    output logic [ADDR_W-1:0]  sp_out
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * WORD_BYTES);

    exc_state_t          state;
    logic [VEC_W-1:0]    vec_q;
    logic                trap_q;
    logic                icm_q;
    logic [PC_W-1:0]     pc_q;
    logic [CCR_W-1:0]    ccr_q;
    logic [ADDR_W-1:0]   sp_q;
    logic                win_valid;
    logic [VEC_W-1:0]    win_vec;
    logic                win_trap;
    logic [CCR_W-1:0]    ccr_next;
    logic                unused_entry_hi;

    exc_arbiter #(
        .NUM_IRQ(NUM_IRQ), .NUM_PER(NUM_PER), .VEC_W(VEC_W),
        .NMI_VEC(NMI_VEC), .TRAP_VEC_BASE(TRAP_VEC_BASE),
        .IRQ_VEC_BASE(IRQ_VEC_BASE), .PER_VEC_BASE(PER_VEC_BASE)
    ) u_arb (
        .nmi(nmi_req), .trap(trap_req), .trap_num(trap_num),
        .irq(irq_req), .per(per_req), .mask(ccr_in[CCR_I_BIT]),
        .win_valid(win_valid), .win_vec(win_vec), .win_trap(win_trap)
    );

    exc_ccr_update u_ccr (
        .ccr_old(ccr_q), .icm(icm_q), .ccr_new(ccr_next)
    );

    // Purpose: sequence state and context captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            vec_q  <= '0;
            trap_q <= 1'b0;
            icm_q  <= 1'b0;
            pc_q   <= '0;
            ccr_q  <= '0;
            sp_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (win_valid) begin
                        state  <= ST_PUSH_PC;
                        vec_q  <= win_vec;
                        trap_q <= win_trap;
                        icm_q  <= icm;
                        pc_q   <= pc_in;
                        ccr_q  <= ccr_in;
                        sp_q   <= sp_in;
                    end
                end
                ST_PUSH_PC:  if (wr_ready) state <= ST_PUSH_CCR;
                ST_PUSH_CCR: if (wr_ready) state <= ST_FETCH;
                ST_FETCH: begin
                    if (rd_valid) begin
                        state <= ST_LOAD;
                        pc_q  <= rd_data[PC_W-1:0];
                    end
                end
                ST_LOAD:     state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: port outputs decoded from the current state.
    always_comb begin
        busy     = (state != ST_IDLE);
        wr_en    = (state == ST_PUSH_PC) || (state == ST_PUSH_CCR);
        wr_addr  = (state == ST_PUSH_CCR) ? (sp_q - STEP2) : (sp_q - STEP1);
        wr_data  = (state == ST_PUSH_CCR) ? DATA_W'(ccr_q) : DATA_W'(pc_q);
        rd_en    = (state == ST_FETCH);
        rd_addr  = ADDR_W'(vec_q) << 2;
        pc_load  = (state == ST_LOAD);
        ccr_load = (state == ST_LOAD);
        pc_out   = pc_q;
        ccr_out  = ccr_next;
        sp_out   = sp_q - STEP2;
    end

    assign unused_entry_hi = ^rd_data[ENTRY_W-1:PC_W];

    assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && nmi_req) |=> (vec_q == VEC_W'(NMI_VEC) && !trap_q));

    assert_trap_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trap_req && !nmi_req) |=> (busy && trap_q));

    assert_mask_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ccr_in[CCR_I_BIT] && !nmi_req && !trap_req) |=> !busy);

    assert_push_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wr_en && wr_data == DATA_W'(pc_q)));

    assert_load_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(rd_valid));

    assert_trap_ui_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_load && trap_q && !icm_q) |->
            (ccr_out[CCR_UI_BIT] == ccr_q[CCR_UI_BIT] && ccr_out[CCR_I_BIT]));

    assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
    typedef struct packed {
        logic       nmi;
        logic [7:0] irq;
        logic [3:0] per;
        logic       trap;
        logic [1:0] tnum;
        logic       icm;
        logic [7:0] ccr;
        logic [7:0] exp_vec;
        logic [7:0] exp_ccr;
    } case_t;

    localparam int NCASE = 9;
    localparam case_t CASES [NCASE] = '{
        '{1'b1, 8'hFF, 4'hF, 1'b1, 2'd2, 1'b0, 8'h80, 8'd7,  8'h80}, // R1 NMI over all, masked
        '{1'b0, 8'h00, 4'h0, 1'b1, 2'd3, 1'b1, 8'h85, 8'd11, 8'hC5}, // R2 R7 trap, I set, mode 1
        '{1'b0, 8'h00, 4'h0, 1'b1, 2'd0, 1'b0, 8'h41, 8'd8,  8'hC1}, // R7 UI kept 1 in mode 0
        '{1'b0, 8'h00, 4'h0, 1'b1, 2'd1, 1'b0, 8'h00, 8'd9,  8'h80}, // R7 UI kept 0 in mode 0
        '{1'b0, 8'hA4, 4'hF, 1'b0, 2'd0, 1'b0, 8'h00, 8'd18, 8'h80}, // R3 R8 lowest IRQ wins
        '{1'b0, 8'h80, 4'h0, 1'b0, 2'd0, 1'b1, 8'h12, 8'd23, 8'hD2}, // R3 R8 IRQ7, mode 1
        '{1'b0, 8'h00, 4'hC, 1'b0, 2'd0, 1'b0, 8'h40, 8'd66, 8'hC0}, // R3 peripheral 2
        '{1'b0, 8'h01, 4'h1, 1'b1, 2'd2, 1'b0, 8'h00, 8'd10, 8'h80}, // R2 trap beats IRQ
        '{1'b1, 8'h00, 4'h0, 1'b0, 2'd0, 1'b1, 8'h3C, 8'd7,  8'hFC}  // R1 R8 NMI mode 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0;
    logic [7:0]  irq_req = '0;
    logic [3:0]  per_req = '0;
    logic        trap_req = 1'b0;
    logic [1:0]  trap_num = '0;
    logic        icm = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  ccr_in = '0;
    logic [15:0] sp_in = '0;
    logic        wr_en, rd_en, busy, pc_load, ccr_load;
    logic [15:0] wr_addr, wr_data, rd_addr, pc_out, sp_out;
    logic [7:0]  ccr_out;
    logic        wr_ready = 1'b1;
    logic [31:0] rd_data = '0;
    logic        rd_valid = 1'b0;
    logic        stall = 1'b0;
    int          cyc = 0;

    int          tests = 0;
    int          fails = 0;
    int          n_wr = 0;
    int          n_rd = 0;
    logic [15:0] wa [2];
    logic [15:0] wd [2];
    logic [15:0] ra;
    logic        seen_load = 1'b0;
    logic [15:0] got_pc, got_sp;
    logic [7:0]  got_ccr;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .per_req(per_req), .trap_req(trap_req), .trap_num(trap_num), .icm(icm),
        .pc_in(pc_in), .ccr_in(ccr_in), .sp_in(sp_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .pc_load(pc_load), .pc_out(pc_out), .ccr_load(ccr_load),
        .ccr_out(ccr_out), .sp_out(sp_out)
    );

    always #2.5 clk = ~clk;

    // Memory model: back-pressured write port, read answered one cycle late.
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        wr_ready <= !stall || (cyc % 3 == 2);
        rd_valid <= rd_en && !rd_valid;
        rd_data  <= {16'hBEEF, 16'h1000 + rd_addr};
    end

    // Monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (wr_en && wr_ready) begin
            if (n_wr < 2) begin
                wa[n_wr] = wr_addr;
                wd[n_wr] = wr_data;
            end
            n_wr++;
        end
        if (rd_en && !rd_valid) begin
            ra = rd_addr;
            n_rd++;
        end
        if (pc_load) begin
            seen_load = 1'b1;
            got_pc  = pc_out;
            got_ccr = ccr_out;
            got_sp  = sp_out;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_wr = 0;
        n_rd = 0;
        seen_load = 1'b0;
    endtask

    task automatic drop_reqs();
        nmi_req = 1'b0; irq_req = '0; per_req = '0; trap_req = 1'b0;
    endtask

    task automatic wait_load(input string req);
        for (int t = 0; t < 100 && !seen_load; t++) @(negedge clk);
        check(seen_load, req, "pc_load seen", seen_load, 1);
    endtask

    task automatic run_case(input case_t c, input int idx, input string req);
        logic [15:0] sp;
        logic [15:0] pc;
        sp = 16'h8000 - 16'(idx * 16);
        pc = 16'h1230 + 16'(idx);
        @(negedge clk);
        clear_log();
        nmi_req = c.nmi; irq_req = c.irq; per_req = c.per;
        trap_req = c.trap; trap_num = c.tnum; icm = c.icm;
        ccr_in = c.ccr; pc_in = pc; sp_in = sp;
        @(negedge clk);
        check(busy == 1'b1, "R9", "busy after accept", busy, 1);
        drop_reqs();
        wait_load(req);
        check(got_pc == 16'h1000 + 16'(c.exp_vec) * 4, req, "vector pc", got_pc,
              16'h1000 + 16'(c.exp_vec) * 4);
        check(got_ccr == c.exp_ccr, req, "ccr_out", got_ccr, c.exp_ccr);
        check(n_wr == 2, "R5", "write count", n_wr, 2);
        check(wa[0] == sp - 2 && wd[0] == pc, "R5", "pc push addr", wa[0], sp - 2);
        check(wd[0] == pc, "R5", "pc push data", wd[0], pc);
        check(wa[1] == sp - 4, "R5", "ccr push addr", wa[1], sp - 4);
        check(wd[1] == {8'h00, c.ccr}, "R5", "ccr push data", wd[1], {8'h00, c.ccr});
        check(n_rd == 1 && ra == 16'(c.exp_vec) * 4, "R6", "vector read addr", ra,
              16'(c.exp_vec) * 4);
        check(got_sp == sp - 4, "R6", "sp_out", got_sp, sp - 4);
        @(negedge clk);
        check(busy == 1'b0, "R9", "busy after load", busy, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: outputs quiet while reset holds, even with requests pending.
        nmi_req = 1'b1; trap_req = 1'b1;
        repeat (3) @(negedge clk);
        check({busy, wr_en, rd_en, pc_load, ccr_load} == 5'b0, "R10", "reset outputs",
              {busy, wr_en, rd_en, pc_load, ccr_load}, 0);
        drop_reqs();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R10", "idle after reset", busy, 0);

        for (int i = 0; i < NCASE; i++) begin
            run_case(CASES[i], i, "R1/R2/R3/R7/R8 case");
        end

        // R4: masked IRQ and peripheral requests start nothing.
        @(negedge clk);
        clear_log();
        irq_req = 8'h01; per_req = 4'h1; ccr_in = 8'h80;
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && n_wr == 0 && n_rd == 0, "R4", "masked start",
              n_wr + n_rd + busy, 0);
        drop_reqs();

        // R5: stalled write port still gives exactly two ordered pushes.
        stall = 1'b1;
        run_case(CASES[4], 20, "R5 stall");
        stall = 1'b0;

        // R9: request changes while busy are ignored.
        @(negedge clk);
        clear_log();
        irq_req = 8'h08; ccr_in = 8'h00; icm = 1'b0; sp_in = 16'h4000;
        @(negedge clk);
        irq_req = '0; nmi_req = 1'b1; trap_req = 1'b1; trap_num = 2'd3;
        @(negedge clk);
        nmi_req = 1'b0; trap_req = 1'b0;
        wait_load("R9");
        check(got_pc == 16'h1000 + 16'd19 * 4, "R9", "vector unchanged", got_pc,
              16'h1000 + 16'd19 * 4);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9", "no second entry", busy, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule